// File: doc/BRIEF.md
# Program Counter and Return-Link Sequencer

This block keeps the architectural program counter of a machine whose instructions are all four bytes long, together with a staged "next" address. While an instruction executes, the staged address starts as the current address plus the instruction size. A control path may replace it with an absolute target or with a signed displacement that is measured from the current address. A commit strobe then retires the instruction: the staged address becomes the program counter, and a fresh staged address is formed.

A save request copies the staged address into a return-link register. The copy uses the value held before any redirect in the same cycle, so a call can capture its return point and branch in one step. The block also keeps a scratch shadow that stands behind the hard-wired zero register. Writes to that register may land there, and every commit clears it again. A registered one-cycle flag reports any redirect that breaks straight-line flow.

Top module: `pc_link_seq`

## Requirements
- R1: While reset is high and after it is released, pc_o equals RESET_VEC, npc_o equals RESET_VEC+4, and link_o, zr_o and jump_o are all zero.
- R2: A commit with no redirect in the same cycle makes pc_o take the previous npc_o, and makes npc_o take that value plus 4.
- R3: An absolute redirect (abs_en) with no commit loads npc_o with abs_tgt on the next edge.
- R4: A relative redirect (rel_en) with no commit loads npc_o with pc_o plus rel_off. rel_off is read as a two's-complement value, and npc_o plus rel_off is never used.
- R5: When abs_en and rel_en are both high, the absolute target wins.
- R6: save_link makes link_o take the npc_o value from before the edge, even when a redirect occurs in the same cycle. Without save_link, link_o holds.
- R7: A commit together with a redirect makes pc_o take the redirected address, and makes npc_o take that address plus 4.
- R8: zr_wr with no commit makes zr_o take zr_wdata. A commit clears zr_o to zero, even when zr_wr is high in the same cycle.
- R9: jump_o is high for exactly the cycle after an edge where a redirect produced an address different from pc_o+4. Otherwise it is low.
- R10: Without a commit, pc_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abs_en | input | 1 | Replace the staged address with abs_tgt |
| abs_tgt | input | AW | Absolute target address |
| rel_en | input | 1 | Replace the staged address with pc_o + rel_off |
| rel_off | input | AW | Signed displacement from pc_o |
| save_link | input | 1 | Copy the staged address into the link register |
| commit | input | 1 | Retire the instruction and install the staged address |
| zr_wr | input | 1 | Write to the zero-register shadow |
| zr_wdata | input | AW | Data for the shadow write |
| pc_o | output | AW | Current program counter |
| npc_o | output | AW | Staged next address |
| link_o | output | AW | Return-link register |
| zr_o | output | AW | Zero-register shadow |
| jump_o | output | 1 | Non-sequential redirect flag |

## Verification
The key collisions in this block are a save request in the same cycle as a redirect, and a commit in the same cycle as a redirect or a shadow write. The bench drives these pairs together in single cycles. It checks that the link captures the pre-redirect staged address, and that a commit both installs the redirected address and forms its successor. It also checks that the clear from the commit beats the same-cycle shadow write. Expected values come from hand-worked vectors with a known reset vector.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ = 2'd0,
    NXT_ABS = 2'd1,
    NXT_REL = 2'd2
  } nxt_src_e;
endpackage

// File: rtl/pcl_target_sel.sv
module pcl_target_sel
  import pcl_pkg::*;
#(
  parameter int AW   = 64,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] npc,
  input  logic          abs_en,
  input  logic [AW-1:0] abs_tgt,
  input  logic          rel_en,
  input  logic [AW-1:0] rel_off,
  output logic [AW-1:0] nxt_val,
  output logic          redirected,
  output logic          breaks_flow
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  nxt_src_e      src;
  logic [AW-1:0] rel_val;
  logic [AW-1:0] seq_val;

  assign rel_val = pc + rel_off;
  assign seq_val = pc + STEP_V;

  // absolute has priority over relative
  always_comb begin
    if (abs_en)      src = NXT_ABS;
    else if (rel_en) src = NXT_REL;
    else             src = NXT_SEQ;
  end

  always_comb begin
    unique case (src)
      NXT_ABS: nxt_val = abs_tgt;
      NXT_REL: nxt_val = rel_val;
      default: nxt_val = npc;
    endcase
  end

  assign redirected  = (src != NXT_SEQ);
  assign breaks_flow = redirected && (nxt_val != seq_val);
endmodule

// File: rtl/pcl_link_reg.sv
module pcl_link_reg #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save,
  input  logic [AW-1:0] staged,
  output logic [AW-1:0] link
);
  always_ff @(posedge clk) begin
    if (rst)       link <= '0;
    else if (save) link <= staged;
  end

  // R6
  link_capture_chk: assert property (@(posedge clk) disable iff (rst)
    save |=> link == $past(staged));
  // R6
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !save |=> $stable(link));
endmodule

// File: rtl/pcl_zero_shadow.sv
module pcl_zero_shadow #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  input  logic          clr,
  output logic [AW-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst || clr) shadow <= '0;
    else if (wr)    shadow <= wdata;
  end

  // R8
  shadow_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> shadow == '0);
  // R8
  shadow_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> shadow == $past(wdata));
endmodule

// File: rtl/pc_link_seq.sv
module pc_link_seq #(
  parameter int              AW        = 64,
  parameter int              STEP      = 4,
  parameter logic [AW-1:0]   RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abs_en,
  input  logic [AW-1:0] abs_tgt,
  input  logic          rel_en,
  input  logic [AW-1:0] rel_off,
  input  logic          save_link,
  input  logic          commit,
  input  logic          zr_wr,
  input  logic [AW-1:0] zr_wdata,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] link_o,
  output logic [AW-1:0] zr_o,
  output logic          jump_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_q, npc_q;
  logic          jump_q;
  logic [AW-1:0] nxt_val;
  logic          redirected, breaks_flow;

  pcl_target_sel #(.AW(AW), .STEP(STEP)) u_sel (
    .pc         (pc_q),
    .npc        (npc_q),
    .abs_en     (abs_en),
    .abs_tgt    (abs_tgt),
    .rel_en     (rel_en),
    .rel_off    (rel_off),
    .nxt_val    (nxt_val),
    .redirected (redirected),
    .breaks_flow(breaks_flow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_VEC;
      npc_q  <= RESET_VEC + STEP_V;
      jump_q <= 1'b0;
    end else begin
      jump_q <= breaks_flow;
      if (commit) begin
        pc_q  <= nxt_val;
        npc_q <= nxt_val + STEP_V;
      end else begin
        npc_q <= nxt_val;
      end
    end
  end

  pcl_link_reg #(.AW(AW)) u_link (
    .clk   (clk),
    .rst   (rst),
    .save  (save_link),
    .staged(npc_q),
    .link  (link_o)
  );

  pcl_zero_shadow #(.AW(AW)) u_zr (
    .clk   (clk),
    .rst   (rst),
    .wr    (zr_wr),
    .wdata (zr_wdata),
    .clr   (commit),
    .shadow(zr_o)
  );

  assign pc_o   = pc_q;
  assign npc_o  = npc_q;
  assign jump_o = jump_q;

  // R2
  seq_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !abs_en && !rel_en) |=> (pc_o == $past(npc_o)) && (npc_o == $past(npc_o) + STEP_V));
  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(pc_o));
  // R3
  abs_load_chk: assert property (@(posedge clk) disable iff (rst)
    (abs_en && !commit) |=> npc_o == $past(abs_tgt));
  // R4
  rel_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !abs_en && !commit) |=> npc_o == $past(pc_o) + $past(rel_off));
  // R9
  no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!abs_en && !rel_en) |=> !jump_o);
  // R1
  reset_pc_chk: assert property (@(posedge clk)
    rst |=> (pc_o == RESET_VEC) && (npc_o == RESET_VEC + STEP_V));
endmodule

// File: tb/pc_link_seq_tb.sv
`timescale 1ns/1ps
module pc_link_seq_tb;
  localparam int            AW = 64;
  localparam logic [AW-1:0] RV = 64'h1000;

  logic          clk = 1'b0;
  logic          rst;
  logic          abs_en, rel_en, save_link, commit, zr_wr;
  logic [AW-1:0] abs_tgt, rel_off, zr_wdata;
  logic [AW-1:0] pc_o, npc_o, link_o, zr_o;
  logic          jump_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pc_link_seq #(.AW(AW), .STEP(4), .RESET_VEC(RV)) u_dut (
    .clk(clk), .rst(rst), .abs_en(abs_en), .abs_tgt(abs_tgt),
    .rel_en(rel_en), .rel_off(rel_off), .save_link(save_link),
    .commit(commit), .zr_wr(zr_wr), .zr_wdata(zr_wdata),
    .pc_o(pc_o), .npc_o(npc_o), .link_o(link_o), .zr_o(zr_o), .jump_o(jump_o)
  );

  typedef struct packed {
    logic          a;
    logic [63:0]   tgt;
    logic          r;
    logic [63:0]   off;
    logic          sv;
    logic          cm;
    logic [63:0]   e_pc;
    logic [63:0]   e_npc;
    logic [63:0]   e_link;
    logic          e_j;
    logic [23:0]   tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    // R2 plain commit
    '{1'b0, 64'h0,    1'b0, 64'h0,  1'b0, 1'b1, 64'h1004, 64'h1008, 64'h0,    1'b0, "R2 "},
    // R4 relative from pc
    '{1'b0, 64'h0,    1'b1, 64'h20, 1'b0, 1'b0, 64'h1004, 64'h1024, 64'h0,    1'b1, "R4 "},
    // R6 save alone
    '{1'b0, 64'h0,    1'b0, 64'h0,  1'b1, 1'b0, 64'h1004, 64'h1024, 64'h1024, 1'b0, "R6 "},
    // R2 commit installs redirected address
    '{1'b0, 64'h0,    1'b0, 64'h0,  1'b0, 1'b1, 64'h1024, 64'h1028, 64'h1024, 1'b0, "R2 "},
    // R6 save with absolute redirect, link gets pre-redirect value
    '{1'b1, 64'h2000, 1'b0, 64'h0,  1'b1, 1'b0, 64'h1024, 64'h2000, 64'h1028, 1'b1, "R6 "},
    // R10 commit after redirect
    '{1'b0, 64'h0,    1'b0, 64'h0,  1'b0, 1'b1, 64'h2000, 64'h2004, 64'h1028, 1'b0, "R10"},
    // R7 negative relative with commit
    '{1'b0, 64'h0,    1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 1'b1, 64'h1FF8, 64'h1FFC, 64'h1028, 1'b1, "R7 "},
    // R9 absolute equal to pc+4: no jump flag
    '{1'b1, 64'h1FFC, 1'b0, 64'h0,  1'b0, 1'b0, 64'h1FF8, 64'h1FFC, 64'h1028, 1'b0, "R9 "},
    // R5 both redirects, absolute wins
    '{1'b1, 64'h3000, 1'b1, 64'h40, 1'b0, 1'b0, 64'h1FF8, 64'h3000, 64'h1028, 1'b1, "R5 "},
    // R4 offset taken from pc, not from staged 3000
    '{1'b0, 64'h0,    1'b1, 64'h4,  1'b0, 1'b0, 64'h1FF8, 64'h1FFC, 64'h1028, 1'b0, "R4 "},
    // R10 idle cycle holds everything
    '{1'b0, 64'h0,    1'b0, 64'h0,  1'b0, 1'b0, 64'h1FF8, 64'h1FFC, 64'h1028, 1'b0, "R10"}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    abs_en = 0; rel_en = 0; save_link = 0; commit = 0; zr_wr = 0;
    abs_tgt = '0; rel_off = '0; zr_wdata = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<5000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    idle_in();
    rst = 1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 pc", pc_o, RV);
    chk("R1 npc", npc_o, RV + 4);
    rst = 0;
    @(negedge clk);
    // R1 after release
    chk("R1 link", link_o, 64'h0);
    chk("R1 zr", zr_o, 64'h0);
    chk("R1 jump", {63'h0, jump_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      abs_en = VT[i].a; abs_tgt = VT[i].tgt;
      rel_en = VT[i].r; rel_off = VT[i].off;
      save_link = VT[i].sv; commit = VT[i].cm;
      @(negedge clk);
      idle_in();
      chk($sformatf("%s v%0d pc", VT[i].tag, i), pc_o, VT[i].e_pc);
      chk($sformatf("%s v%0d npc", VT[i].tag, i), npc_o, VT[i].e_npc);
      chk($sformatf("%s v%0d link", VT[i].tag, i), link_o, VT[i].e_link);
      chk($sformatf("%s v%0d jump", VT[i].tag, i), {63'h0, jump_o}, {63'h0, VT[i].e_j});
    end

    // R3 absolute load with no commit
    abs_en = 1; abs_tgt = 64'h0000_00AB_CDEF_0010;
    @(negedge clk); idle_in();
    chk("R3 npc", npc_o, 64'h0000_00AB_CDEF_0010);
    chk("R9 jump set", {63'h0, jump_o}, 64'h1);
    @(negedge clk);
    chk("R9 jump one cycle", {63'h0, jump_o}, 64'h0);

    // R8 shadow write, then a commit clears it
    zr_wr = 1; zr_wdata = 64'hDEAD_BEEF_1234_5678;
    @(negedge clk); idle_in();
    chk("R8 zr write", zr_o, 64'hDEAD_BEEF_1234_5678);
    commit = 1;
    @(negedge clk); idle_in();
    chk("R8 zr cleared", zr_o, 64'h0);
    chk("R2 pc", pc_o, 64'h0000_00AB_CDEF_0010);
    // R8 commit wins over same-cycle write
    zr_wr = 1; zr_wdata = 64'h55; commit = 1;
    @(negedge clk); idle_in();
    chk("R8 commit over write", zr_o, 64'h0);
    chk("R2 pc step", pc_o, 64'h0000_00AB_CDEF_0014);

    // R7 absolute redirect with commit and save
    abs_en = 1; abs_tgt = 64'h4000; commit = 1; save_link = 1;
    @(negedge clk); idle_in();
    chk("R7 pc", pc_o, 64'h4000);
    chk("R7 npc", npc_o, 64'h4004);
    chk("R6 link", link_o, 64'h0000_00AB_CDEF_0018);

    // R1 mid-run reset
    rst = 1; zr_wr = 1; zr_wdata = 64'h9;
    @(negedge clk);
    rst = 0; idle_in();
    @(negedge clk);
    chk("R1 pc again", pc_o, RV);
    chk("R1 npc again", npc_o, RV + 4);
    chk("R1 link again", link_o, 64'h0);
    chk("R1 zr again", zr_o, 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule